// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a set of external interrupt pins and turns their activity into interrupt requests for a CPU interrupt controller. Software chooses for every pin the event that counts as an interrupt: a low level, a high level, a falling edge, a rising edge or either edge. Each pin owns one pending flag and one mask flag. Pins are arranged eight to a bank, and each bank has three registers: a trigger configuration register, a mask register and a pending register.

Every pin passes through a two-flop synchronizer before its trigger is evaluated. A qualifying event sets the pin's pending flag whether or not the pin is masked. The mask only decides whether a pending flag reaches a request output. The lower sixteen pins each own a dedicated request line. The upper sixteen pins are ORed onto one shared request line, and the handler finds the source by reading the pending and mask registers of banks 2 and 3.

Registers are accessed over a plain synchronous bus. A write takes effect at the rising clock edge while `bus_we` is high. Read data is combinational from `bus_addr`. No data stream crosses the block's edge, so it has no valid/ready handshake and every pin is a plain control or status signal.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every trigger field holds 7 (disabled), so a configuration register reads 0x7777_7777. Every mask register reads 0x0000_00FF, every pending register reads 0, and all request outputs are 0.
- R2: `bus_addr[3:2]` selects the register kind: 0 for configuration, 1 for mask, 2 for pending. Kind 3 reads 0. `bus_addr[1:0]` selects the bank. The trigger field of lane k sits in configuration bits [4k+2:4k], and bit 4k+3 always reads 0. Mask and pending use bits [7:0], and bits [31:8] read 0.
- R3: Code 3 (rising edge) sets pending only on a 0-to-1 change of the synchronized pin. The flag then stays set after the pin returns low.
- R4: Code 2 (falling edge) sets pending only on a 1-to-0 change. Code 4 (both edges) sets pending on either change.
- R5: Code 0 (low level) and code 1 (high level) set pending on every cycle the active level is present, so a clear does not stick while that level holds. Once the level is gone, a clear does stick.
- R6: Codes 5, 6 and 7 never set pending, whatever the pin does.
- R7: Writing the pending register clears every bit written as 1. Bits written as 0 keep their value.
- R8: A masked pin (mask bit 1) still sets its pending flag, but its request does not reach any output.
- R9: For pins 0 to 15, `irq_low_o[i]` is high exactly when pin i is pending and unmasked.
- R10: `irq_shared_o` is high exactly when at least one of pins 16 to 31 is pending and unmasked.
- R11: When a qualifying event and a clear of the same pin land on the same clock edge, the pending flag ends at 1.
- R12: A pin change applied between clock edges shows in pending after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | External interrupt pins (asynchronous) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register kind [3:2] and bank [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_low_o | output | 16 | Dedicated requests for pins 0 to 15 |
| irq_shared_o | output | 1 | Combined request for pins 16 to 31 |

## Verification
The bench hits a software clear on the same edge as a rising edge on the pin. A design that lets the clear win would lose that interrupt. It clears a level-triggered pin while its level is still present, to catch a design that treats levels as one-shot edges. It also writes zeros to the pending register, which a design that decodes the write wrongly would treat as a clear. It samples pending after the second and after the third edge following a pin change, so a synchronizer one flop short or one flop long is caught. It also checks that a masked pin still sets pending, that a rising-edge pin ignores falling edges, and that codes 5 to 7 stay silent.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [2:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4,
    TRIG_OFF  = 3'd7
  } trig_e;
  localparam int FIELD_W = 4;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/eirq_lane.sv
module eirq_lane
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_s,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wd,
  input  logic       clr,
  output logic [2:0] cfg_q,
  output logic       pend_q
);
  trig_e mode_q;
  logic  prev_q;
  logic  hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRIG_OFF;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_s;
      if (cfg_we) mode_q <= trig_e'(cfg_wd);
      // a new event outranks a same-edge clear
      pend_q <= (pend_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (mode_q)
      TRIG_LOW:  hit = ~lvl_s;
      TRIG_HIGH: hit = lvl_s;
      TRIG_FALL: hit = prev_q & ~lvl_s;
      TRIG_RISE: hit = ~prev_q & lvl_s;
      TRIG_BOTH: hit = prev_q ^ lvl_s;
      default:   hit = 1'b0;
    endcase
  end

  assign cfg_q = mode_q;
endmodule

// File: rtl/eirq_bank.sv
module eirq_bank
  import eirq_pkg::*;
#(
  parameter int LANES = 8,
  localparam int DW = LANES * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin_s,
  input  logic             cfg_we,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cfg_rd,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wdata[LANES-1:0];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [2:0] code;
    eirq_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_s  (pin_s[k]),
      .cfg_we (cfg_we),
      .cfg_wd (wdata[k*FIELD_W +: 3]),
      .clr    (clr_we & wdata[k]),
      .cfg_q  (code),
      .pend_q (pend_q[k])
    );
    assign cfg_rd[k*FIELD_W +: FIELD_W] = {1'b0, code};
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PPB       = 8,
  parameter int DEDICATED = 16,
  localparam int NP     = NUM_BANKS * PPB,
  localparam int DW     = PPB * FIELD_W,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = BANK_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        pin_i,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic [DEDICATED-1:0] irq_low_o,
  output logic                 irq_shared_o
);
  localparam logic [1:0] KIND_CFG  = 2'd0;
  localparam logic [1:0] KIND_MASK = 2'd1;
  localparam logic [1:0] KIND_PEND = 2'd2;

  logic [1:0]        kind;
  logic [BANK_W-1:0] bank;
  logic [NP-1:0]     pin_s;
  logic [NP-1:0]     pend_all;
  logic [NP-1:0]     mask_all;
  logic [DW-1:0]     cfg_rd [NUM_BANKS];

  assign kind = bus_addr[ADDR_W-1 -: 2];
  assign bank = bus_addr[BANK_W-1:0];

  eirq_sync #(.W(NP)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = bus_we && (bank == BANK_W'(b));
    eirq_bank #(.LANES(PPB)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s[b*PPB +: PPB]),
      .cfg_we  (hit_bank && kind == KIND_CFG),
      .mask_we (hit_bank && kind == KIND_MASK),
      .clr_we  (hit_bank && kind == KIND_PEND),
      .wdata   (bus_wdata),
      .cfg_rd  (cfg_rd[b]),
      .mask_q  (mask_all[b*PPB +: PPB]),
      .pend_q  (pend_all[b*PPB +: PPB])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (kind)
      KIND_CFG:  bus_rdata = cfg_rd[bank];
      KIND_MASK: bus_rdata[PPB-1:0] = mask_all[bank*PPB +: PPB];
      KIND_PEND: bus_rdata[PPB-1:0] = pend_all[bank*PPB +: PPB];
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_low_o    = pend_all[DEDICATED-1:0] & ~mask_all[DEDICATED-1:0];
  assign irq_shared_o = |(pend_all[NP-1:DEDICATED] & ~mask_all[NP-1:DEDICATED]);
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int NP  = 32,
  parameter int PPB = 8,
  parameter int DED = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [3:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [DED-1:0] irq_low_o,
  input logic          irq_shared_o,
  input logic [NP-1:0] pend_all,
  input logic [NP-1:0] mask_all
);
  assert_cfg_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd0) |-> ((bus_rdata & 32'h8888_8888) == 32'h0));

  assert_flag_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] != 2'd0) |-> (bus_rdata[31:8] == 24'h0));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_low_o & mask_all[DED-1:0]) == '0));

  assert_shared_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared_o |-> ((pend_all[NP-1:DED] & ~mask_all[NP-1:DED]) != '0));

  assert_low_follows_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_low_o != '0) |-> ((pend_all[DED-1:0] & irq_low_o) == irq_low_o));

  for (genvar i = 0; i < NP; i++) begin : g_drop
    assert_drop_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_all[i]) |-> $past(bus_we && bus_addr[3:2] == 2'd2 &&
                                   bus_addr[1:0] == 2'(i / PPB) && bus_wdata[i % PPB]));
  end
endmodule

bind ext_irq_ctrl eirq_checker #(.NP(32), .PPB(8), .DED(16)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq_low_o    (irq_low_o),
  .irq_shared_o (irq_shared_o),
  .pend_all     (pend_all),
  .mask_all     (mask_all)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_low_o;
  logic        irq_shared_o;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_low_o(irq_low_o), .irq_shared_o(irq_shared_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] kind, logic [1:0] bank, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {kind, bank}; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] kind, logic [1:0] bank, output logic [31:0] d);
    bus_addr = {kind, bank};
    #1 d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int b = 0; b < 4; b++) begin
      rd(2'd0, 2'(b), d); check("R1 cfg reset", d, 32'h7777_7777);
      rd(2'd1, 2'(b), d); check("R1 mask reset", d, 32'h0000_00FF);
      rd(2'd2, 2'(b), d); check("R1 pend reset", d, 32'h0);
    end
    check("R1 irq reset", {15'h0, irq_shared_o, irq_low_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 2'd1, 32'hFFFF_FFFF); rd(2'd0, 2'd1, d);
    check("R2 cfg msb zero", d, 32'h7777_7777);
    wr(2'd1, 2'd2, 32'hFFFF_FF12); rd(2'd1, 2'd2, d);
    check("R2 mask width", d, 32'h12);
    rd(2'd3, 2'd2, d); check("R2 kind3 reads 0", d, 32'h0);
    wr(2'd1, 2'd2, 32'hFF);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    wr(2'd0, 2'd0, 32'h7777_3777);            // pin 3 rising
    @(negedge clk); pin_i[3] = 1'b1;
    idle(2); rd(2'd2, 2'd0, d); check("R12 not after 2 edges", d, 32'h0);
    idle(1); rd(2'd2, 2'd0, d); check("R12 after 3 edges", d, 32'h08);
    check("R8 masked output", {16'h0, irq_low_o}, 32'h0);
    @(negedge clk); pin_i[3] = 1'b0; idle(5);
    rd(2'd2, 2'd0, d); check("R3 edge held", d, 32'h08);
    wr(2'd1, 2'd0, 32'hF7);
    check("R9 dedicated line", {16'h0, irq_low_o}, 32'h0008);
    wr(2'd2, 2'd0, 32'h00); rd(2'd2, 2'd0, d); check("R7 zero write no effect", d, 32'h08);
    wr(2'd2, 2'd0, 32'h08); rd(2'd2, 2'd0, d); check("R7 clear", d, 32'h0);
    check("R9 line drops", {16'h0, irq_low_o}, 32'h0);
    wr(2'd1, 2'd0, 32'hFF);
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    wr(2'd0, 2'd0, 32'h7427_7777);            // pin 5 falling, pin 6 both
    @(negedge clk); pin_i[5] = 1'b1; idle(4);
    rd(2'd2, 2'd0, d); check("R4 fall ignores rise", d, 32'h0);
    @(negedge clk); pin_i[5] = 1'b0; idle(4);
    rd(2'd2, 2'd0, d); check("R4 fall sets", d, 32'h20);
    wr(2'd2, 2'd0, 32'h20);
    @(negedge clk); pin_i[6] = 1'b1; idle(4);
    rd(2'd2, 2'd0, d); check("R4 both on rise", d, 32'h40);
    wr(2'd2, 2'd0, 32'h40);
    @(negedge clk); pin_i[6] = 1'b0; idle(4);
    rd(2'd2, 2'd0, d); check("R4 both on fall", d, 32'h40);
    wr(2'd2, 2'd0, 32'h40);
    wr(2'd0, 2'd0, 32'h7777_7777);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(2'd0, 2'd2, 32'h7771_7777);            // pin 20 high level
    wr(2'd1, 2'd2, 32'hEF);
    @(negedge clk); pin_i[20] = 1'b1; idle(4);
    check("R10 shared on", {31'h0, irq_shared_o}, 32'h1);
    wr(2'd2, 2'd2, 32'h10); rd(2'd2, 2'd2, d);
    check("R5 high level re-sets", d, 32'h10);
    @(negedge clk); pin_i[20] = 1'b0; idle(4);
    wr(2'd2, 2'd2, 32'h10); rd(2'd2, 2'd2, d);
    check("R5 clear sticks after level", d, 32'h0);
    check("R10 shared off", {31'h0, irq_shared_o}, 32'h0);
    wr(2'd0, 2'd2, 32'h7777_7777);
    wr(2'd1, 2'd2, 32'hFF);
    wr(2'd0, 2'd1, 32'h7777_7707);            // pin 9 low level, pin low
    idle(2); rd(2'd2, 2'd1, d); check("R5 low level sets", d, 32'h02);
    wr(2'd2, 2'd1, 32'h02); rd(2'd2, 2'd1, d); check("R5 low re-sets", d, 32'h02);
    @(negedge clk); pin_i[9] = 1'b1; idle(4);
    wr(2'd2, 2'd1, 32'h02); idle(3); rd(2'd2, 2'd1, d);
    check("R5 low clear sticks", d, 32'h0);
    wr(2'd0, 2'd1, 32'h7777_7777);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    for (int c = 5; c < 8; c++) begin
      wr(2'd0, 2'd1, 32'h7777_7777 & ~(32'h7 << 16) | (32'(c) << 16)); // pin 12
      @(negedge clk); pin_i[12] = ~pin_i[12]; idle(4);
      @(negedge clk); pin_i[12] = ~pin_i[12]; idle(4);
      rd(2'd2, 2'd1, d); check("R6 disabled code silent", d, 32'h02 & 32'h0);
    end
    wr(2'd0, 2'd1, 32'h7777_7777);
  endtask

  task automatic t_shared_masked();
    logic [31:0] d;
    wr(2'd0, 2'd3, 32'h7377_7777);            // pin 30 rising
    @(negedge clk); pin_i[30] = 1'b1; idle(4);
    rd(2'd2, 2'd3, d); check("R8 masked pend sets", d, 32'h40);
    check("R8 shared masked", {31'h0, irq_shared_o}, 32'h0);
    wr(2'd1, 2'd3, 32'hBF);
    check("R10 shared unmasked", {31'h0, irq_shared_o}, 32'h1);
    check("R9 low lines unaffected", {16'h0, irq_low_o}, 32'h0);
    wr(2'd2, 2'd3, 32'h40); wr(2'd1, 2'd3, 32'hFF);
    wr(2'd0, 2'd3, 32'h7777_7777);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(2'd0, 2'd0, 32'h7777_7377);            // pin 2 rising
    @(negedge clk); pin_i[2] = 1'b1; idle(4);
    @(negedge clk); pin_i[2] = 1'b0; idle(4); // pend holds 1
    @(negedge clk); pin_i[2] = 1'b1;
    @(negedge clk);
    wr(2'd2, 2'd0, 32'h04);                   // lands on the setting edge
    rd(2'd2, 2'd0, d); check("R11 set beats clear", d, 32'h04);
    wr(2'd2, 2'd0, 32'h04); rd(2'd2, 2'd0, d); check("R11 later clear", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_rising();
    t_fall_both();
    t_level();
    t_disabled();
    t_shared_masked();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule